// File: doc/BRIEF.md
# Root Port Message and Legacy Interrupt Collector

This block gathers the interrupts that a root port receives from downstream devices and presents them to the processor as one request line. Message-signalled interrupts arrive as inbound posted memory writes. When such a write targets the programmed 32-bit doorbell address, its data value names one of 32 vectors. The matching bit of a per-vector pending register is set and an MSI flag in a summary register is raised. Four legacy INTx level lines are sampled every cycle, and each one that is high latches its own flag in the same summary register.

Software programs the doorbell address and a mask through a small word-indexed CSR port. It reads the summary register to see which class of source is pending. For MSI it drains the per-vector register by writing ones back to it, and it clears the MSI summary flag only once that register reads zero. All status bits are write-one-to-clear. The interrupt output is high while any summary flag is set and not masked. Vector allocation and the transaction layer sit outside this block.

Top module: `rp_irq_agg`

## Requirements
- R1: After reset, the doorbell register, the pending register and the summary register read 0. The mask register reads 0x008F0000 (every source masked), and irqOut is 0.
- R2: CSR word index 0 is the doorbell address, 1 the pending register, 2 the summary register and 3 the mask register. Reads return data combinationally from csrAddr. A mask write keeps only bit 23 and bits 19:16, and every other mask bit reads 0.
- R3: An inbound write with inWrAddr equal to the doorbell register and inWrData = d, with d < 32, sets bit d of the pending register. The bit is visible from the next clock edge.
- R4: An inbound write is ignored, leaving the pending register and summary bit 23 unchanged, if its address does not match the doorbell or its data is 32 or more. Data lines are likewise ignored while inWrValid is low.
- R5: A CSR write to the pending register clears each bit written as 1 and leaves each bit written as 0.
- R6: Every accepted doorbell write sets summary bit 23. This includes a vector that arrives after software has cleared bit 23.
- R7: When intxLevel[i] is high at a clock edge, summary bit 16+i is set. The bit stays set after the line falls, until software writes 1 to it.
- R8: Summary bits are write-one-to-clear. When a set and a clear hit the same summary bit in one cycle, the set wins.
- R9: irqOut is 1 exactly when some summary bit (23 or 19:16) is set while the mask bit at the same position is 0.
- R10: When a doorbell write and a pending-register clear hit the same vector in one cycle, the vector stays set. Other bits in the clear are still cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWrValid | input | 1 | Inbound posted memory write present this cycle |
| inWrAddr | input | 32 | Address of the inbound write |
| inWrData | input | 32 | Data of the inbound write (vector number) |
| intxLevel | input | 4 | Legacy INTx level lines, synchronous to clk |
| csrWrEn | input | 1 | CSR write strobe |
| csrAddr | input | 2 | CSR word index |
| csrWrData | input | 32 | CSR write data |
| csrRdData | output | 32 | CSR read data for csrAddr |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench targets the collisions. One is a doorbell write landing in the same cycle as a pending clear of that vector. If clear won, that interrupt would be lost for good. Another is a summary clear coinciding with a new doorbell write or a still-high INTx line; a wrong priority would leave pending work with no summary flag and no interrupt. The bench also sends doorbell writes with data 32 and 0xFFFFFFFF, and a write to a neighbouring address. A design that truncated the data or matched loosely would set a low vector. Finally it checks that masking suppresses irqOut without disturbing the latched status. A design that gated status instead of output would then drop events once the source was unmasked.

// File: rtl/rp_irq_agg_pkg.sv
package rp_irq_agg_pkg;

  // CSR word indices
  localparam int IDX_DOORBELL = 0;
  localparam int IDX_PENDING  = 1;
  localparam int IDX_SUMMARY  = 2;
  localparam int IDX_MASK     = 3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic wrDoorbell;
    logic wrPendClr;
    logic wrSumClr;
    logic wrMask;
    logic msiHit;
  } agg_strobe_t;

endpackage

// File: rtl/rp_irq_agg_ctrl.sv
module rp_irq_agg_ctrl
  import rp_irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_VEC = 32,
  parameter int CSR_AW  = 2
) (
  input  logic                          inWrValid,
  input  logic [ADDR_W-1:0]             inWrAddr,
  input  logic [DATA_W-1:0]             inWrData,
  input  logic [ADDR_W-1:0]             dbAddr,
  input  logic                          csrWrEn,
  input  logic [CSR_AW-1:0]             csrAddr,
  output agg_strobe_t                   strobe,
  output logic [$clog2(NUM_VEC)-1:0]    msiVec
);
  localparam int VEC_IDX_W = $clog2(NUM_VEC);

  logic addrMatch;
  logic dataInRange;

  always_comb begin
    addrMatch   = (inWrAddr == dbAddr);
    dataInRange = (inWrData < DATA_W'(NUM_VEC));
    msiVec      = inWrData[VEC_IDX_W-1:0];

    strobe            = '0;
    strobe.msiHit     = inWrValid && addrMatch && dataInRange;
    strobe.wrDoorbell = csrWrEn && (csrAddr == CSR_AW'(IDX_DOORBELL));
    strobe.wrPendClr  = csrWrEn && (csrAddr == CSR_AW'(IDX_PENDING));
    strobe.wrSumClr   = csrWrEn && (csrAddr == CSR_AW'(IDX_SUMMARY));
    strobe.wrMask     = csrWrEn && (csrAddr == CSR_AW'(IDX_MASK));
  end

endmodule

// File: rtl/rp_irq_agg_dp.sv
module rp_irq_agg_dp
  import rp_irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_VEC  = 32,
  parameter int NUM_INTX = 4,
  parameter int MSI_BIT  = 23,
  parameter int INTX_LSB = 16,
  parameter int CSR_AW   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  agg_strobe_t                   strobe,
  input  logic [$clog2(NUM_VEC)-1:0]    msiVec,
  input  logic [NUM_INTX-1:0]           intxLevel,
  input  logic [DATA_W-1:0]             csrWrData,
  input  logic [CSR_AW-1:0]             csrAddr,
  output logic [DATA_W-1:0]             csrRdData,
  output logic [ADDR_W-1:0]             dbAddr,
  output logic [NUM_VEC-1:0]            pendVec,
  output logic [DATA_W-1:0]             sumStat,
  output logic [DATA_W-1:0]             maskReg,
  output logic                          irqOut
);
  logic [NUM_VEC-1:0]  vecSet;
  logic                sumMsi;
  logic                maskMsi;
  logic [NUM_INTX-1:0] sumIntx;
  logic [NUM_INTX-1:0] maskIntx;

  assign vecSet = strobe.msiHit ? (NUM_VEC'(1) << msiVec) : '0;

  // doorbell address register
  always_ff @(posedge clk) begin
    if (!rstN) dbAddr <= '0;
    else if (strobe.wrDoorbell) dbAddr <= csrWrData[ADDR_W-1:0];
  end

  // per-vector pending bits: arrival beats clear
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) pendVec[v] <= 1'b0;
      else if (vecSet[v]) pendVec[v] <= 1'b1;
      else if (strobe.wrPendClr && csrWrData[v]) pendVec[v] <= 1'b0;
    end
  end

  // MSI summary flag and its mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumMsi  <= 1'b0;
      maskMsi <= 1'b1;
    end else begin
      if (strobe.msiHit) sumMsi <= 1'b1;
      else if (strobe.wrSumClr && csrWrData[MSI_BIT]) sumMsi <= 1'b0;
      if (strobe.wrMask) maskMsi <= csrWrData[MSI_BIT];
    end
  end

  // legacy line flags and their masks
  for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumIntx[i]  <= 1'b0;
        maskIntx[i] <= 1'b1;
      end else begin
        if (intxLevel[i]) sumIntx[i] <= 1'b1;
        else if (strobe.wrSumClr && csrWrData[INTX_LSB+i]) sumIntx[i] <= 1'b0;
        if (strobe.wrMask) maskIntx[i] <= csrWrData[INTX_LSB+i];
      end
    end
  end

  always_comb begin
    sumStat                      = '0;
    sumStat[MSI_BIT]             = sumMsi;
    sumStat[INTX_LSB+:NUM_INTX]  = sumIntx;
    maskReg                      = '0;
    maskReg[MSI_BIT]             = maskMsi;
    maskReg[INTX_LSB+:NUM_INTX]  = maskIntx;
  end

  always_comb begin
    unique case (csrAddr)
      CSR_AW'(IDX_DOORBELL): csrRdData = DATA_W'(dbAddr);
      CSR_AW'(IDX_PENDING):  csrRdData = DATA_W'(pendVec);
      CSR_AW'(IDX_SUMMARY):  csrRdData = sumStat;
      default:               csrRdData = maskReg;
    endcase
  end

  assign irqOut = (sumMsi && !maskMsi) || (|(sumIntx & ~maskIntx));

endmodule

// File: rtl/rp_irq_agg.sv
module rp_irq_agg
  import rp_irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_VEC  = 32,
  parameter int NUM_INTX = 4,
  parameter int MSI_BIT  = 23,
  parameter int INTX_LSB = 16,
  parameter int CSR_AW   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inWrValid,
  input  logic [ADDR_W-1:0]   inWrAddr,
  input  logic [DATA_W-1:0]   inWrData,
  input  logic [NUM_INTX-1:0] intxLevel,
  input  logic                csrWrEn,
  input  logic [CSR_AW-1:0]   csrAddr,
  input  logic [DATA_W-1:0]   csrWrData,
  output logic [DATA_W-1:0]   csrRdData,
  output logic                irqOut
);
  localparam int VEC_IDX_W = $clog2(NUM_VEC);

  agg_strobe_t          strobe;
  logic [VEC_IDX_W-1:0] msiVec;
  logic [ADDR_W-1:0]    dbAddr;
  logic [NUM_VEC-1:0]   pendVec;
  logic [DATA_W-1:0]    sumStat;
  logic [DATA_W-1:0]    maskReg;

  rp_irq_agg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .CSR_AW(CSR_AW)
  ) u_ctrl (
    .inWrValid(inWrValid),
    .inWrAddr (inWrAddr),
    .inWrData (inWrData),
    .dbAddr   (dbAddr),
    .csrWrEn  (csrWrEn),
    .csrAddr  (csrAddr),
    .strobe   (strobe),
    .msiVec   (msiVec)
  );

  rp_irq_agg_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX),
    .MSI_BIT(MSI_BIT), .INTX_LSB(INTX_LSB), .CSR_AW(CSR_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .msiVec   (msiVec),
    .intxLevel(intxLevel),
    .csrWrData(csrWrData),
    .csrAddr  (csrAddr),
    .csrRdData(csrRdData),
    .dbAddr   (dbAddr),
    .pendVec  (pendVec),
    .sumStat  (sumStat),
    .maskReg  (maskReg),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/rp_irq_agg_chk.sv
module rp_irq_agg_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_VEC  = 32,
  parameter int NUM_INTX = 4,
  parameter int MSI_BIT  = 23,
  parameter int INTX_LSB = 16,
  parameter int CSR_AW   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                inWrValid,
  input logic [ADDR_W-1:0]   inWrAddr,
  input logic [DATA_W-1:0]   inWrData,
  input logic [NUM_INTX-1:0] intxLevel,
  input logic                csrWrEn,
  input logic [CSR_AW-1:0]   csrAddr,
  input logic [DATA_W-1:0]   csrWrData,
  input logic                irqOut,
  input logic [ADDR_W-1:0]   dbAddr,
  input logic [NUM_VEC-1:0]  pendVec,
  input logic [DATA_W-1:0]   sumStat,
  input logic [DATA_W-1:0]   maskReg
);
  localparam int VEC_IDX_W = $clog2(NUM_VEC);

  logic accepted;
  logic rejected;
  logic pendClrWr;
  logic sumClrWr;

  assign accepted  = inWrValid && (inWrAddr == dbAddr) && (inWrData < DATA_W'(NUM_VEC));
  assign rejected  = inWrValid && !accepted;
  assign pendClrWr = csrWrEn && (csrAddr == CSR_AW'(1));
  assign sumClrWr  = csrWrEn && (csrAddr == CSR_AW'(2));

  AST_VEC_SET: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> pendVec[$past(inWrData[VEC_IDX_W-1:0])]); // R3

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    rejected && !pendClrWr |=> $stable(pendVec)); // R4

  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rstN)
    pendClrWr && !inWrValid |=> ((pendVec & $past(csrWrData[NUM_VEC-1:0])) == '0)); // R5

  AST_MSI_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> sumStat[MSI_BIT]); // R6

  AST_SUM_W1C: assert property (@(posedge clk) disable iff (!rstN)
    sumClrWr && csrWrData[MSI_BIT] && !inWrValid |=> !sumStat[MSI_BIT]); // R8

  AST_QUIET_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (sumStat == '0) |-> !irqOut); // R9

  AST_UNMASKED_MSI: assert property (@(posedge clk) disable iff (!rstN)
    (sumStat[MSI_BIT] && !maskReg[MSI_BIT]) |-> irqOut); // R9

  for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx_chk
    AST_INTX_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      intxLevel[i] |=> sumStat[INTX_LSB+i]); // R7
  end

endmodule

bind rp_irq_agg rp_irq_agg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX),
  .MSI_BIT(MSI_BIT), .INTX_LSB(INTX_LSB), .CSR_AW(CSR_AW)
) u_chk (.*);

// File: tb/rp_irq_agg_bench.sv
module rp_irq_agg_bench;
  localparam logic [31:0] DB       = 32'h1000_0040;
  localparam logic [31:0] SUM_BITS = 32'h008F_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inWrValid = 1'b0;
  logic [31:0] inWrAddr = '0;
  logic [31:0] inWrData = '0;
  logic [3:0]  intxLevel = '0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrAddr = '0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // expectation model, built from the requirements
  logic [31:0] mDb = '0, mPend = '0, mSum = '0, mMask = SUM_BITS;

  // scoreboard queues
  logic [1:0]  addrQ[$];
  logic [31:0] dataQ[$];
  logic        irqQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  rp_irq_agg u_rp_irq_agg (
    .clk(clk), .rstN(rstN), .inWrValid(inWrValid), .inWrAddr(inWrAddr),
    .inWrData(inWrData), .intxLevel(intxLevel), .csrWrEn(csrWrEn),
    .csrAddr(csrAddr), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .irqOut(irqOut)
  );

  task automatic modelEdge(input bit we, input logic [1:0] a, input logic [31:0] d,
                           input bit dv, input logic [31:0] da, input logic [31:0] dd);
    bit hit;
    logic [31:0] pClr, sClr, sSet;
    hit  = dv && (da == mDb) && (dd < 32);
    pClr = (we && a == 2'd1) ? d : 32'h0;
    sClr = (we && a == 2'd2) ? d : 32'h0;
    sSet = {8'h0, hit, 3'b000, intxLevel, 16'h0};
    mPend = (mPend & ~pClr) | (hit ? (32'h1 << dd[4:0]) : 32'h0);
    mSum  = ((mSum & ~sClr) | sSet) & SUM_BITS;
    if (we && a == 2'd3) mMask = d & SUM_BITS;
    if (we && a == 2'd0) mDb = d;
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d,
                      input bit dv, input logic [31:0] da, input logic [31:0] dd);
    @(negedge clk);
    csrWrEn = we; csrAddr = a; csrWrData = d;
    inWrValid = dv; inWrAddr = da; inWrData = dd;
    @(posedge clk);
    modelEdge(we, a, d, dv, da, dd);
    #1;
    csrWrEn = 1'b0; inWrValid = 1'b0;
  endtask

  task automatic csrWr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic ring(input logic [31:0] da, input logic [31:0] dd);
    step(1'b0, 2'd0, 32'h0, 1'b1, da, dd);
  endtask

  task automatic setIntx(input logic [3:0] lvl);
    @(negedge clk);
    intxLevel = lvl;
    @(posedge clk);
    modelEdge(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 32'h0);
    #1;
  endtask

  task automatic expectReg(input logic [1:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    csrAddr = a;
    case (a)
      2'd0: e = mDb;
      2'd1: e = mPend;
      2'd2: e = mSum;
      default: e = mMask;
    endcase
    addrQ.push_back(a);
    dataQ.push_back(e);
    irqQ.push_back(|(mSum & ~mMask));
    tagQ.push_back(tag);
    @(posedge clk);
    modelEdge(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 32'h0);
    #1;
  endtask

  // monitor: compares design outputs against queued expectations
  always @(negedge clk) begin
    #5;
    while (tagQ.size() > 0) begin
      logic [1:0]  a;
      logic [31:0] e;
      logic        ei;
      string       t;
      a = addrQ.pop_front();
      e = dataQ.pop_front();
      ei = irqQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (csrRdData !== e || irqOut !== ei) begin
        nFails++;
        $display("FAIL %s reg=%0d data got=%h exp=%h irq got=%b exp=%b",
                 t, a, csrRdData, e, irqOut, ei);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(2'd0, "R1");
    expectReg(2'd1, "R1");
    expectReg(2'd2, "R1");
    expectReg(2'd3, "R1");

    // R2 register map and mask field retention
    csrWr(2'd0, DB);
    expectReg(2'd0, "R2");
    csrWr(2'd3, 32'hFFFF_FFFF);
    expectReg(2'd3, "R2");

    // R3 vectors set by data value
    ring(DB, 32'd0);
    ring(DB, 32'd31);
    ring(DB, 32'd5);
    expectReg(2'd1, "R3");
    expectReg(2'd2, "R3");

    // R4 ignored writes
    ring(DB + 32'd4, 32'd7);
    ring(DB, 32'd32);
    ring(DB, 32'hFFFF_FFFF);
    step(1'b0, 2'd0, 32'h0, 1'b0, DB, 32'd9);
    expectReg(2'd1, "R4");

    // R5 partial write-one-to-clear
    csrWr(2'd1, 32'h0000_0021);
    expectReg(2'd1, "R5");

    // R6 summary re-raised by a later vector
    csrWr(2'd2, 32'h0080_0000);
    expectReg(2'd2, "R6");
    ring(DB, 32'd12);
    expectReg(2'd2, "R6");
    expectReg(2'd1, "R6");

    // R9 masking of MSI
    csrWr(2'd3, 32'h000F_0000);
    expectReg(2'd2, "R9");
    csrWr(2'd3, 32'h008F_0000);
    expectReg(2'd3, "R9");

    // R7 latched legacy line
    setIntx(4'b0010);
    setIntx(4'b0000);
    expectReg(2'd2, "R7");
    csrWr(2'd2, 32'h0002_0000);
    expectReg(2'd2, "R7");

    // R8 clear against a still-high line
    setIntx(4'b1000);
    csrWr(2'd2, 32'h0008_0000);
    expectReg(2'd2, "R8");
    setIntx(4'b0000);
    csrWr(2'd2, 32'h0008_0000);
    expectReg(2'd2, "R7");

    // R8 summary clear and doorbell in one cycle
    step(1'b1, 2'd2, 32'h0080_0000, 1'b1, DB, 32'd3);
    expectReg(2'd2, "R8");

    // R10 pending clear and doorbell on same vector
    step(1'b1, 2'd1, 32'h0000_1008, 1'b1, DB, 32'd3);
    expectReg(2'd1, "R10");

    // R9 unmasked legacy line drives the output
    csrWr(2'd3, 32'h0080_0000);
    setIntx(4'b0001);
    expectReg(2'd2, "R9");
    setIntx(4'b0000);
    csrWr(2'd2, 32'h008F_0000);
    expectReg(2'd2, "R9");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule